// File: doc/BRIEF.md
# Control Byte Command Dispatcher

This block sits behind a serial control port receiver. It watches the bytes of one addressed transfer, between the frame-open and frame-close pulses, and turns them into register-write commands for a bank of nine function registers. Each byte is sorted by its top bit. A clear top bit makes it a function selector. A set top bit makes it a value for the function that is currently selected.

A selector picks one of nine functions and one of two modes. In sticky mode every value that follows goes to the same function. In stepping mode each value goes to the next function in a ring of nine: the first value lands one past the selected index, the next one two past it, and so on. The function number is carried in the selector with its bits reversed. Selectors and values may be mixed freely inside one frame.

Each accepted value produces a one-cycle write strobe with the function index and the 7-bit payload, one clock after the byte is presented.

Top module: `cmd_dispatch`

## Requirements
- R1: A byte accepted with bit 7 = 0 is a selector; it never produces a write strobe.
- R2: A byte accepted with bit 7 = 1, while a selector is active, raises `wr_en` for exactly the next cycle, with `wr_val` = byte bits 6..0. In sticky mode (selector bit 0 = 0) every such value targets the same index.
- R3: The selector index is bit6·1 + bit5·2 + bit4·4 when bits 6..4 are not all ones. When bits 6..4 are all ones it is 7 + bit3. Bit 3 is ignored in every other case, and bits 2..1 are always ignored.
- R4: Selector bit 0 = 1 selects stepping mode: the first value goes to index+1, the second to index+2, and so on.
- R5: In stepping mode index 8 steps to 0, and index 7 steps to 8.
- R6: Values that arrive in a frame before any selector are dropped and produce no write.
- R7: Bytes are accepted only inside a frame. A byte presented while no frame is open is ignored, and so is a byte presented in the same cycle as `frame_end`.
- R8: `frame_start` clears the selection and the mode. A byte presented in the same cycle as `frame_start` is treated as the first byte of the new frame. When both frame pulses are high in one cycle, the start wins.
- R9: A new selector inside a frame replaces both the index and the mode for the values that follow it.
- R10: During and right after reset, `wr_en` is 0 and no function is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse: a new addressed transfer begins |
| frame_end | input | 1 | One-cycle pulse: the current transfer is over |
| byte_valid | input | 1 | `byte_data` holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| wr_en | output | 1 | Register-write strobe |
| wr_idx | output | 4 | Function index of the write (0..8) |
| wr_val | output | 7 | Payload of the write |

## Verification
Two events can land in the same cycle: a frame-open pulse and a byte, and a frame-close pulse and a byte. The first must clear the old selection and still take the byte as part of the new frame. The second must drop the byte. Directed steps place a value or a selector exactly on each pulse. The random phase then raises pulses and bytes independently, so these overlaps recur many times. Each cycle is judged against a bench model that applies the frame pulse first and the byte second, and then compares the strobe, index and payload seen one clock later.

// File: rtl/cmd_disp_pkg.sv
package cmd_disp_pkg;
  localparam int BYTE_W   = 8;
  localparam int PAY_W    = BYTE_W - 1;
  localparam int NUM_FUNC = 9;
  localparam int IDX_W    = $clog2(NUM_FUNC);

  typedef logic [IDX_W-1:0] func_idx_t;

  // Reversed index field: bit6 is weight 1, bit5 weight 2, bit4 weight 4;
  // bit3 extends 7 to 8 only when the low three weights are all set.
  function automatic func_idx_t decode_func(input logic [PAY_W-1:0] sel);
    logic [2:0] low;
    low = {sel[4], sel[5], sel[6]};
    if (&low) decode_func = func_idx_t'(7) + func_idx_t'(sel[3]);
    else      decode_func = func_idx_t'(low);
  endfunction

  function automatic func_idx_t advance_func(input func_idx_t cur);
    if (cur >= func_idx_t'(NUM_FUNC - 1)) advance_func = '0;
    else                                  advance_func = cur + func_idx_t'(1);
  endfunction
endpackage

// File: rtl/cmd_frame_ctl.sv
module cmd_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_end,
  input  logic byte_valid,
  output logic in_frame,
  output logic accept
);
  assign accept = byte_valid && (frame_start || (in_frame && !frame_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           in_frame <= 1'b0;
    else if (frame_start) in_frame <= 1'b1;
    else if (frame_end)   in_frame <= 1'b0;
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> in_frame); // R8
endmodule

// File: rtl/cmd_classify.sv
module cmd_classify
  import cmd_disp_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              accept,
  output logic              sub_fire,
  output logic              data_fire,
  output func_idx_t         sub_idx,
  output logic              sub_inc,
  output logic [PAY_W-1:0]  payload
);
  assign payload   = byte_data[PAY_W-1:0];
  assign sub_fire  = accept && !byte_data[BYTE_W-1];
  assign data_fire = accept &&  byte_data[BYTE_W-1];
  assign sub_idx   = decode_func(payload);
  assign sub_inc   = byte_data[0];

  always_comb begin
    assert (!(sub_fire && data_fire)); // R1
  end
endmodule

// File: rtl/cmd_sel_track.sv
module cmd_sel_track
  import cmd_disp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_start,
  input  logic      sub_fire,
  input  func_idx_t sub_idx,
  input  logic      sub_inc,
  input  logic      data_fire,
  output logic      sel_vld,
  output func_idx_t sel_idx,
  output logic      inc_mode,
  output func_idx_t tgt_idx,
  output logic      tgt_ok
);
  logic      eff_vld;
  logic      eff_inc;
  func_idx_t eff_idx;

  // A frame-open pulse wipes the selection before the same-cycle byte is used.
  assign eff_vld = sel_vld  && !frame_start;
  assign eff_inc = inc_mode && !frame_start;
  assign eff_idx = frame_start ? '0 : sel_idx;
  assign tgt_ok  = data_fire && eff_vld;
  assign tgt_idx = eff_inc ? advance_func(eff_idx) : eff_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld  <= 1'b0;
      sel_idx  <= '0;
      inc_mode <= 1'b0;
    end else if (sub_fire) begin
      sel_vld  <= 1'b1;
      sel_idx  <= sub_idx;
      inc_mode <= sub_inc;
    end else begin
      sel_vld  <= eff_vld;
      inc_mode <= eff_inc;
      sel_idx  <= tgt_ok ? tgt_idx : eff_idx;
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !sub_fire) |=> (!sel_vld && !inc_mode)); // R8
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && sel_vld && !inc_mode && !frame_start) |=> $stable(sel_idx)); // R2
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && sel_vld && inc_mode && !frame_start && sel_idx == func_idx_t'(NUM_FUNC-1))
      |=> (sel_idx == '0)); // R5
  AST_NEW_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sub_fire |=> (sel_vld && inc_mode == $past(sub_inc))); // R9
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [PAY_W-1:0]  wr_val
);
  logic             in_frame_w;
  logic             accept_w;
  logic             sub_fire_w;
  logic             data_fire_w;
  func_idx_t        sub_idx_w;
  logic             sub_inc_w;
  logic [PAY_W-1:0] payload_w;
  logic             sel_vld_w;
  func_idx_t        sel_idx_w;
  logic             inc_mode_w;
  func_idx_t        tgt_idx_w;
  logic             tgt_ok_w;

  cmd_frame_ctl u_frame (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_valid(byte_valid), .in_frame(in_frame_w), .accept(accept_w)
  );

  cmd_classify u_class (
    .byte_data(byte_data), .accept(accept_w), .sub_fire(sub_fire_w),
    .data_fire(data_fire_w), .sub_idx(sub_idx_w), .sub_inc(sub_inc_w),
    .payload(payload_w)
  );

  cmd_sel_track u_sel (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sub_fire(sub_fire_w),
    .sub_idx(sub_idx_w), .sub_inc(sub_inc_w), .data_fire(data_fire_w),
    .sel_vld(sel_vld_w), .sel_idx(sel_idx_w), .inc_mode(inc_mode_w),
    .tgt_idx(tgt_idx_w), .tgt_ok(tgt_ok_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_val <= '0;
    end else begin
      wr_en <= tgt_ok_w;
      if (tgt_ok_w) begin
        wr_idx <= tgt_idx_w;
        wr_val <= payload_w;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_FUNC))); // R3
  AST_SUB_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_fire_w |=> !wr_en); // R1
  AST_NO_SEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire_w && (!sel_vld_w || frame_start)) |=> !wr_en); // R6
  AST_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !frame_start && (!in_frame_w || frame_end)) |=> !wr_en); // R7
  AST_DATA_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_val == $past(byte_data[PAY_W-1:0]))); // R2
endmodule

// File: tb/cmd_dispatch_test.sv
`timescale 1ns/1ps
module cmd_dispatch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, frame_end = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       wr_en;
  logic [3:0] wr_idx;
  logic [6:0] wr_val;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit       m_in = 0, m_vld = 0, m_inc = 0;
  int       m_idx = 0;

  always #2.5 clk = ~clk;

  cmd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  function automatic int ref_index(input logic [7:0] b);
    int w;
    w = (b[6] ? 1 : 0) + (b[5] ? 2 : 0) + (b[4] ? 4 : 0);
    if (w == 7 && b[3]) return 8;
    return w;
  endfunction

  function automatic int ref_next(input int i);
    return (i == 8) ? 0 : i + 1;
  endfunction

  task automatic check(input string tag, input bit e_en, input int e_idx, input int e_val);
    n_chk++;
    if (wr_en !== e_en || (e_en && (int'(wr_idx) != e_idx || int'(wr_val) != e_val))) begin
      n_bad++;
      $display("FAIL %s: en=%0d idx=%0d val=%0d, expected en=%0d idx=%0d val=%0d",
               tag, wr_en, wr_idx, wr_val, e_en, e_idx, e_val);
    end
  endtask

  task automatic step(input bit fs, input bit fe, input bit bv, input logic [7:0] bd,
                      input string tag);
    bit acc, e_en;
    int e_idx, e_val;
    frame_start = fs; frame_end = fe; byte_valid = bv; byte_data = bd;
    @(posedge clk);
    acc = bv && (fs || (m_in && !fe));
    if (fs) begin m_vld = 0; m_inc = 0; m_idx = 0; end
    m_in = fs ? 1'b1 : (fe ? 1'b0 : m_in);
    e_en = 0; e_idx = 0; e_val = 0;
    if (acc) begin
      if (!bd[7]) begin
        m_idx = ref_index(bd); m_inc = bd[0]; m_vld = 1;
      end else if (m_vld) begin
        if (m_inc) m_idx = ref_next(m_idx);
        e_en = 1; e_idx = m_idx; e_val = int'(bd[6:0]);
      end
    end
    #1;
    check(tag, e_en, e_idx, e_val);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", 0, 0, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 8'h00, "R10 after reset");

    // R7: value outside any frame
    step(0, 0, 1, 8'h00, "R7 selector outside frame");
    step(0, 0, 1, 8'h85, "R7 value outside frame");
    // R8/R6: start with a value in the same cycle: no selection yet
    step(1, 0, 1, 8'h93, "R6 value on frame start");
    step(0, 0, 1, 8'h94, "R6 value before selector");
    // R1/R2 sticky on index 0
    step(0, 0, 1, 8'h00, "R1 selector no write");
    step(0, 0, 1, 8'h85, "R2 sticky first");
    step(0, 0, 1, 8'hFF, "R2 sticky second");
    step(0, 0, 1, 8'hC0, "R2 sticky third");
    // R3 decode cases
    step(0, 0, 1, 8'h40, "R3 sel bit6");
    step(0, 0, 1, 8'h81, "R3 idx1");
    step(0, 0, 1, 8'h08, "R3 bit3 alone");
    step(0, 0, 1, 8'h82, "R3 idx0 bit3 ignored");
    step(0, 0, 1, 8'h78, "R3 sel all");
    step(0, 0, 1, 8'h83, "R3 idx8");
    step(0, 0, 1, 8'h70, "R3 sel 7");
    step(0, 0, 1, 8'h84, "R3 idx7");
    step(0, 0, 1, 8'h26, "R3 bits2-1 ignored");
    step(0, 0, 1, 8'h86, "R3 idx2");
    // R4/R5 stepping from 7
    step(0, 0, 1, 8'h71, "R4 stepping sel 7");
    step(0, 0, 1, 8'h91, "R5 7 to 8");
    step(0, 0, 1, 8'h92, "R5 8 wraps to 0");
    step(0, 0, 1, 8'h93, "R4 0 to 1");
    step(0, 0, 0, 8'h00, "R2 idle gap");
    // R9 mid-frame replacement
    step(0, 0, 1, 8'h20, "R9 new sticky sel");
    step(0, 0, 1, 8'hAA, "R9 sticky idx2");
    step(0, 0, 1, 8'hAB, "R9 sticky idx2 again");
    // R8 close, then start carrying a stepping selector
    step(0, 1, 0, 8'h00, "R7 frame end");
    step(0, 0, 1, 8'hB0, "R7 value after end");
    step(1, 0, 1, 8'h11, "R8 selector on start");
    step(0, 0, 1, 8'hC5, "R8 stepping to 5");
    step(0, 1, 1, 8'hC6, "R7 value on frame end");
    step(1, 1, 1, 8'h50, "R8 start beats end");
    step(0, 0, 1, 8'h8F, "R8 frame open after both");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] b;
      bit fs, fe, bv;
      fs = ($urandom % 20) == 0;
      fe = ($urandom % 25) == 0;
      bv = ($urandom % 10) < 6;
      b  = 8'($urandom);
      if (($urandom % 4) != 0) b[7] = 1'b1;
      step(fs, fe, bv, b, "R4 R2 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7344));
  end
endmodule